// File: doc/BRIEF.md
# Script Processor Branch Unit

This block carries out the transfer-control instructions of a small script processor that drives a parallel peripheral bus. It owns the instruction pointer, a single-entry return register, and the interrupt status. For each instruction it is given, it evaluates one shared condition and then decides the next pointer value. The condition is either a test of the ALU carry flag, or a comparison of the latched bus phase and/or the latched data byte. A polarity bit in the instruction decides whether a match or a mismatch counts as taken.

Each instruction is two 32-bit words, so 8 bytes long: an instruction word and an operand word. The pointer is treated as already advanced past the current instruction, so the next sequential address is the pointer plus 8. A jump loads an absolute or relative target. A call also saves the sequential address into the return register. A return restores that saved address. An interrupt instruction comes in two forms. The halting form raises the interrupt line and stops the processor until the host writes the pointer. The on-the-fly form only sets a sticky status flag, and execution goes on.

Instruction word fields:

| Bits | Field |
|------|-------|
| 29:27 | Operation select |
| 26:24 | Expected phase |
| 23 | Relative addressing |
| 21 | Carry test select |
| 20 | On-the-fly interrupt form |
| 19 | Polarity |
| 18 | Data compare enable |
| 17 | Phase compare enable |
| 15:8 | Data mask |
| 7:0 | Data compare byte |

Top module: `scr_branch_unit`

## Requirements
- R1: After a synchronous reset, next_ip, ret_ip and int_vector are 0, and irq, fly_flag and halted are 0.
- R2: When instruction bit 21 is 1, the match result equals alu_carry, and the phase and data compares are not used.
- R3: When bit 21 is 0 and bit 17 is 1, the phase compare matches when bus_phase equals instruction bits 26:24. The phase code is ordered message, control/data, in/out (000 data out, 001 data in, 010 command, 011 status, 110 message out, 111 message in). When target_mode is 1, the phase compare always matches.
- R4: When bit 21 is 0 and bit 18 is 1, the data compare matches when bus_data equals instruction bits 7:0 in every bit position where the mask in bits 15:8 is 0. A mask bit of 1 excludes that position.
- R5: An instruction is taken when the match result equals polarity bit 19. When bits 21, 18 and 17 are all 0, the match result is 1.
- R6: The operation code in bits 29:27 selects the action: 000 jump, 001 call, 010 return, 011 interrupt. A taken jump loads next_ip from the operand. Any instruction that is not taken sets next_ip to next_ip+8.
- R7: When bit 23 is 1 on a jump or call, the target is next_ip+8 plus the sign-extended operand bits 23:0. Operand bits 31:24 are then ignored.
- R8: A taken call writes next_ip+8 into ret_ip and branches as a jump would. A call that is not taken leaves ret_ip unchanged.
- R9: A taken return loads next_ip from ret_ip and ignores bit 23. It does not check for a prior call and raises no interrupt.
- R10: A taken interrupt with bit 20 at 0 sets irq and halted, stores the operand in int_vector, and sets next_ip to next_ip+8. While halted, instructions have no effect. A host pointer write loads next_ip from host_ip_wdata and clears irq and halted. A host pointer write has priority over an instruction in the same cycle.
- R11: A taken interrupt with bit 20 at 1 sets fly_flag and stores the operand in int_vector. It leaves irq and halted at 0 and advances next_ip by 8. fly_flag stays 1 until a fly_clr pulse.
- R12: Operation codes 100 to 111 act as no-ops: next_ip becomes next_ip+8 whatever the condition, and no other output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Execute instr/operand this cycle |
| instr | input | 32 | Instruction word |
| operand | input | 32 | Operand word (target, offset or status vector) |
| alu_carry | input | 1 | ALU carry flag |
| bus_phase | input | 3 | Phase latched at the bus request |
| bus_data | input | 8 | Data byte latched from the bus |
| target_mode | input | 1 | 1 = target role, phase compare ignored |
| host_ip_we | input | 1 | Host write strobe for the pointer |
| host_ip_wdata | input | 32 | Host pointer value |
| fly_clr | input | 1 | Write-one-to-clear for fly_flag |
| next_ip | output | 32 | Instruction pointer |
| ret_ip | output | 32 | Saved return address |
| int_vector | output | 32 | Status vector of the last taken interrupt |
| irq | output | 1 | Interrupt request |
| fly_flag | output | 1 | On-the-fly interrupt status |
| halted | output | 1 | Processor halted |

## Verification
All outputs are registered. An instruction, host write or clear that is presented before a rising edge shows its result on that same edge: next_ip, ret_ip, int_vector, irq, halted and fly_flag are all due one cycle after the stimulus. Each scenario task drives its inputs on a falling edge and removes them on the following falling edge. It then reads the outputs at that falling edge, half a period after the single edge that updated them. No check depends on the order in which processes run at an edge. Some cases need the pointer to stay where it is, such as a halted processor ignoring a jump. For those, the bench reads next_ip one cycle after the ignored instruction and compares it with the value from before.

// File: rtl/scr_branch_pkg.sv
package scr_branch_pkg;

  localparam int INSTR_W = 32;
  localparam int PH_W    = 3;
  localparam int BYTE_W  = 8;

  localparam logic [2:0] OPC_JUMP = 3'b000;
  localparam logic [2:0] OPC_CALL = 3'b001;
  localparam logic [2:0] OPC_RET  = 3'b010;
  localparam logic [2:0] OPC_INT  = 3'b011;

  typedef struct packed {
    logic [2:0]        opc;
    logic [PH_W-1:0]   phase;
    logic              rel;
    logic              carry_sel;
    logic              fly;
    logic              polarity;
    logic              data_en;
    logic              phase_en;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] cmp;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [INSTR_W-1:0] w);
    ctl_t c;
    c.opc       = w[29:27];
    c.phase     = w[26:24];
    c.rel       = w[23];
    c.carry_sel = w[21];
    c.fly       = w[20];
    c.polarity  = w[19];
    c.data_en   = w[18];
    c.phase_en  = w[17];
    c.mask      = w[15:8];
    c.cmp       = w[7:0];
    return c;
  endfunction

endpackage

// File: rtl/scr_cond_eval.sv
module scr_cond_eval
  import scr_branch_pkg::*;
#(
  parameter int PHASE_W = PH_W,
  parameter int DATA_W  = BYTE_W
) (
  input  ctl_t               ctl,
  input  logic               alu_carry,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               target_mode,
  output logic               match,
  output logic               taken
);

  logic phase_ok;
  logic data_ok;
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff     = (bus_data ^ ctl.cmp) & ~ctl.mask;
    data_ok  = (diff == '0);
    phase_ok = target_mode || (bus_phase == ctl.phase);
    if (ctl.carry_sel) begin
      match = alu_carry;
    end else begin
      match = (!ctl.phase_en || phase_ok) && (!ctl.data_en || data_ok);
    end
    taken = (match == ctl.polarity);
  end

endmodule

// File: rtl/scr_target_calc.sv
module scr_target_calc
  import scr_branch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 24
) (
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] seq_ip,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] ret_ip,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offset = {{EXT_W{operand[OFFS_W-1]}}, operand[OFFS_W-1:0]};
    end else begin : g_full
      assign offset = operand;
    end
  endgenerate

  always_comb begin
    if (ctl.opc == OPC_RET) begin
      target = ret_ip;
    end else if (ctl.rel) begin
      target = seq_ip + offset;
    end else begin
      target = operand;
    end
  end

endmodule

// File: rtl/scr_int_status.sv
module scr_int_status #(
  parameter int VEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_take,
  input  logic             fly_take,
  input  logic             host_we,
  input  logic             fly_clr,
  input  logic [VEC_W-1:0] operand,
  output logic             irq,
  output logic             halted,
  output logic             fly_flag,
  output logic [VEC_W-1:0] int_vector
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      halted     <= 1'b0;
      fly_flag   <= 1'b0;
      int_vector <= '0;
    end else begin
      if (host_we) begin
        irq    <= 1'b0;
        halted <= 1'b0;
      end else if (int_take) begin
        irq    <= 1'b1;
        halted <= 1'b1;
      end
      if (fly_take) begin
        fly_flag <= 1'b1;
      end else if (fly_clr) begin
        fly_flag <= 1'b0;
      end
      if (int_take || fly_take) begin
        int_vector <= operand;
      end
    end
  end

  // R10
  irq_halt_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> halted);

  // R11
  fly_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fly_flag) |-> !$rose(halted));

  // R11
  fly_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fly_flag && !fly_clr) |=> fly_flag);

endmodule

// File: rtl/scr_branch_unit.sv
module scr_branch_unit
  import scr_branch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFFS_W      = 24,
  parameter int INSTR_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] operand,
  input  logic              alu_carry,
  input  logic [2:0]        bus_phase,
  input  logic [7:0]        bus_data,
  input  logic              target_mode,
  input  logic              host_ip_we,
  input  logic [ADDR_W-1:0] host_ip_wdata,
  input  logic              fly_clr,
  output logic [ADDR_W-1:0] next_ip,
  output logic [ADDR_W-1:0] ret_ip,
  output logic [ADDR_W-1:0] int_vector,
  output logic              irq,
  output logic              fly_flag,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  ctl_t              ctl;
  logic              match;
  logic              taken;
  logic              exec;
  logic [ADDR_W-1:0] seq_ip;
  logic [ADDR_W-1:0] target;
  logic              is_int;
  logic              int_take;
  logic              fly_take;

  assign ctl    = decode_ctl(instr);
  assign exec   = instr_valid && !halted && !host_ip_we;
  assign seq_ip = next_ip + STEP;
  assign is_int = (ctl.opc == OPC_INT);

  scr_cond_eval #(
    .PHASE_W(PH_W),
    .DATA_W (BYTE_W)
  ) u_cond (
    .ctl        (ctl),
    .alu_carry  (alu_carry),
    .bus_phase  (bus_phase),
    .bus_data   (bus_data),
    .target_mode(target_mode),
    .match      (match),
    .taken      (taken)
  );

  scr_target_calc #(
    .ADDR_W(ADDR_W),
    .OFFS_W(OFFS_W)
  ) u_tgt (
    .ctl    (ctl),
    .seq_ip (seq_ip),
    .operand(operand),
    .ret_ip (ret_ip),
    .target (target)
  );

  assign int_take = exec && taken && is_int && !ctl.fly;
  assign fly_take = exec && taken && is_int && ctl.fly;

  scr_int_status #(
    .VEC_W(ADDR_W)
  ) u_stat (
    .clk       (clk),
    .rst       (rst),
    .int_take  (int_take),
    .fly_take  (fly_take),
    .host_we   (host_ip_we),
    .fly_clr   (fly_clr),
    .operand   (operand),
    .irq       (irq),
    .halted    (halted),
    .fly_flag  (fly_flag),
    .int_vector(int_vector)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_ip <= '0;
      ret_ip  <= '0;
    end else if (host_ip_we) begin
      next_ip <= host_ip_wdata;
    end else if (exec) begin
      case (ctl.opc)
        OPC_JUMP, OPC_RET: next_ip <= taken ? target : seq_ip;
        OPC_CALL: begin
          if (taken) begin
            ret_ip  <= seq_ip;
            next_ip <= target;
          end else begin
            next_ip <= seq_ip;
          end
        end
        default: next_ip <= seq_ip;
      endcase
    end
  end

  // R10
  host_wr_chk: assert property (@(posedge clk) disable iff (rst)
    host_ip_we |=> (next_ip == $past(host_ip_wdata)) && !halted);

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !host_ip_we) |=> $stable(next_ip) && $stable(ret_ip));

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !halted && !host_ip_we && !taken) |=> next_ip == $past(next_ip) + STEP);

  // R8
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && taken && ctl.opc == OPC_CALL) |=> ret_ip == $past(next_ip) + STEP);

endmodule

// File: tb/test_scr_branch_unit.sv
module test_scr_branch_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] operand = '0;
  logic        alu_carry = 1'b0;
  logic [2:0]  bus_phase = '0;
  logic [7:0]  bus_data = '0;
  logic        target_mode = 1'b0;
  logic        host_ip_we = 1'b0;
  logic [31:0] host_ip_wdata = '0;
  logic        fly_clr = 1'b0;
  logic [31:0] next_ip, ret_ip, int_vector;
  logic        irq, fly_flag, halted;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scr_branch_unit i_scr_branch_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .operand(operand), .alu_carry(alu_carry), .bus_phase(bus_phase),
    .bus_data(bus_data), .target_mode(target_mode), .host_ip_we(host_ip_we),
    .host_ip_wdata(host_ip_wdata), .fly_clr(fly_clr), .next_ip(next_ip),
    .ret_ip(ret_ip), .int_vector(int_vector), .irq(irq),
    .fly_flag(fly_flag), .halted(halted)
  );

  function automatic logic [31:0] mk(input logic [2:0] opc, input logic rel,
      input logic csel, input logic fly, input logic pol, input logic den,
      input logic pen, input logic [2:0] ph, input logic [7:0] mask,
      input logic [7:0] cmp);
    logic [31:0] w;
    w = '0;
    w[29:27] = opc; w[26:24] = ph; w[23] = rel; w[21] = csel;
    w[20] = fly; w[19] = pol; w[18] = den; w[17] = pen;
    w[15:8] = mask; w[7:0] = cmp;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exec_i(input logic [31:0] w, input logic [31:0] op);
    @(negedge clk);
    instr = w; operand = op; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic host_wr(input logic [31:0] v);
    @(negedge clk);
    host_ip_we = 1'b1; host_ip_wdata = v;
    @(negedge clk);
    host_ip_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 next_ip", next_ip, 0);
    chk("R1 ret_ip", ret_ip, 0);
    chk("R1 int_vector", int_vector, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fly_flag", {31'b0, fly_flag}, 0);
    chk("R1 halted", {31'b0, halted}, 0);
  endtask

  task automatic t_jump();
    host_wr(32'h100);
    chk("R10 host write", next_ip, 32'h100);
    exec_i(mk(3'b000, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'h400);
    chk("R6 R5 jump unconditional", next_ip, 32'h400);
    exec_i(mk(3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0), 32'h900);
    chk("R5 R6 jump never", next_ip, 32'h408);
  endtask

  task automatic t_carry();
    alu_carry = 1'b1;
    exec_i(mk(3'b000, 0, 1, 0, 1, 0, 1, 3'd5, 0, 0), 32'h800);
    chk("R2 carry set taken", next_ip, 32'h800);
    alu_carry = 1'b0;
    exec_i(mk(3'b000, 0, 1, 0, 1, 0, 0, 0, 0, 0), 32'hA00);
    chk("R2 carry clear not taken", next_ip, 32'h808);
  endtask

  task automatic t_phase();
    bus_phase = 3'd3;
    exec_i(mk(3'b000, 0, 0, 0, 1, 0, 1, 3'd3, 0, 0), 32'h1000);
    chk("R3 phase match", next_ip, 32'h1000);
    bus_phase = 3'd2;
    exec_i(mk(3'b000, 0, 0, 0, 1, 0, 1, 3'd3, 0, 0), 32'h1800);
    chk("R3 phase mismatch", next_ip, 32'h1008);
    target_mode = 1'b1;
    exec_i(mk(3'b000, 0, 0, 0, 1, 0, 1, 3'd3, 0, 0), 32'h2000);
    chk("R3 target mode ignores phase", next_ip, 32'h2000);
    target_mode = 1'b0;
  endtask

  task automatic t_data();
    bus_data = 8'hA0;
    exec_i(mk(3'b000, 0, 0, 0, 1, 1, 0, 0, 8'h0F, 8'hA5), 32'h3000);
    chk("R4 masked data match", next_ip, 32'h3000);
    bus_data = 8'h55;
    exec_i(mk(3'b000, 0, 0, 0, 1, 1, 0, 0, 8'h0F, 8'hA5), 32'h3800);
    chk("R4 data mismatch", next_ip, 32'h3008);
    exec_i(mk(3'b000, 0, 0, 0, 0, 1, 0, 0, 8'h0F, 8'hA5), 32'h4000);
    chk("R5 false polarity on mismatch", next_ip, 32'h4000);
  endtask

  task automatic t_rel();
    exec_i(mk(3'b000, 1, 0, 0, 1, 0, 0, 0, 0, 0), 32'h00FF_FFF0);
    chk("R7 negative offset", next_ip, 32'h3FF8);
    exec_i(mk(3'b000, 1, 0, 0, 1, 0, 0, 0, 0, 0), 32'hAB00_0100);
    chk("R7 positive offset high bits ignored", next_ip, 32'h4100);
  endtask

  task automatic t_call_ret();
    host_wr(32'h500);
    exec_i(mk(3'b001, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'h9000);
    chk("R8 call target", next_ip, 32'h9000);
    chk("R8 call saves return", ret_ip, 32'h508);
    exec_i(mk(3'b001, 0, 0, 0, 0, 0, 0, 0, 0, 0), 32'hB000);
    chk("R8 untaken call ret", ret_ip, 32'h508);
    chk("R8 untaken call ip", next_ip, 32'h9008);
    exec_i(mk(3'b010, 1, 0, 0, 1, 0, 0, 0, 0, 0), 32'h12);
    chk("R9 return ignores relative", next_ip, 32'h508);
    exec_i(mk(3'b010, 0, 0, 0, 0, 0, 0, 0, 0, 0), 32'h0);
    chk("R9 untaken return", next_ip, 32'h510);
    exec_i(mk(3'b101, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'h7777);
    chk("R12 no-op advances", next_ip, 32'h518);
    chk("R12 no-op no irq", {31'b0, irq}, 0);
  endtask

  task automatic t_int();
    exec_i(mk(3'b011, 1, 0, 0, 1, 0, 0, 0, 0, 0), 32'hCAFE_0001);
    chk("R10 irq", {31'b0, irq}, 1);
    chk("R10 halted", {31'b0, halted}, 1);
    chk("R10 vector", int_vector, 32'hCAFE_0001);
    chk("R10 ip advanced", next_ip, 32'h520);
    exec_i(mk(3'b000, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'h9999);
    chk("R10 halted ignores jump", next_ip, 32'h520);
    @(negedge clk);
    host_ip_we = 1'b1; host_ip_wdata = 32'h600;
    instr = mk(3'b000, 0, 0, 0, 1, 0, 0, 0, 0, 0); operand = 32'h7000;
    instr_valid = 1'b1;
    @(negedge clk);
    host_ip_we = 1'b0; instr_valid = 1'b0;
    chk("R10 host write wins", next_ip, 32'h600);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    chk("R10 halt cleared", {31'b0, halted}, 0);
    exec_i(mk(3'b011, 0, 0, 0, 0, 0, 0, 0, 0, 0), 32'h1);
    chk("R10 untaken int", {31'b0, irq}, 0);
    chk("R10 untaken int ip", next_ip, 32'h608);
  endtask

  task automatic t_fly();
    exec_i(mk(3'b011, 0, 0, 1, 1, 0, 0, 0, 0, 0), 32'h55);
    chk("R11 fly set", {31'b0, fly_flag}, 1);
    chk("R11 no halt", {31'b0, halted}, 0);
    chk("R11 no irq", {31'b0, irq}, 0);
    chk("R11 ip advanced", next_ip, 32'h610);
    chk("R11 vector", int_vector, 32'h55);
    exec_i(mk(3'b000, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'h700);
    chk("R11 keeps running", next_ip, 32'h700);
    chk("R11 flag sticky", {31'b0, fly_flag}, 1);
    @(negedge clk);
    fly_clr = 1'b1;
    @(negedge clk);
    fly_clr = 1'b0;
    chk("R11 flag cleared", {31'b0, fly_flag}, 0);
  endtask

  task automatic t_unmatched_ret();
    do_reset();
    host_wr(32'h40);
    exec_i(mk(3'b010, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'h0);
    chk("R9 unmatched return ip", next_ip, 32'h0);
    chk("R9 unmatched return no irq", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_jump();
    t_carry();
    t_phase();
    t_data();
    t_rel();
    t_call_ret();
    t_int();
    t_fly();
    t_unmatched_ret();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule